// File: doc/BRIEF.md
# Single-Precision Float to Saturating Int16 Converter

This block turns a 32-bit single-precision floating-point word into a 16-bit two's complement integer. It splits the word into its sign, biased exponent and stored fraction, and puts back the implicit leading one of normal numbers. It then aligns the significand against the binary point and drops every fractional bit, so the result is truncated toward zero.

A value whose truncated integer does not fit the 16-bit range is clamped to the nearest limit. It never wraps. Zero and subnormal exponents, infinities and NaNs are each recognised and handled on their own path. Three status outputs report clamping, an infinite input and a NaN input.

A client presents a word with a valid strobe. The result, the flags and a matching valid appear one clock later. When no word is presented, the output register holds its last contents.

Top module: `f2i_sat16`

## Requirements
- R1: A word taken while `in_valid` is high produces its result, its flags and `out_valid` high on the next rising clock edge. While `in_valid` is low, `out_valid` falls and `out_int` and all flags keep their previous values.
- R2: While reset is active, `out_valid`, `out_int`, `out_sat`, `out_inf` and `out_nan` are all 0.
- R3: The input layout is sign in bit 31, biased exponent in bits 30:23 (bias 127) and fraction in bits 22:0. A normal value whose truncated integer lies in −32768..32767 appears on `out_int` as the two's complement of that integer, truncated toward zero, with all flags low.
- R4: Exponent field 0 (zero of either sign or any subnormal), and any normal value of magnitude below 1.0, give `out_int` = 0 with all flags low.
- R5: A positive finite value whose truncated integer exceeds 32767 gives 32767 (0x7FFF) with `out_sat` high and `out_inf` low.
- R6: A negative finite value whose truncated integer is below −32768 gives −32768 (0x8000) with `out_sat` high. Values from −32768.0 down to, but not including, −32769.0 give 0x8000 with `out_sat` low.
- R7: Exponent field 255 with a zero fraction gives 0x7FFF for a positive sign and 0x8000 for a negative sign, with both `out_inf` and `out_sat` high and `out_nan` low.
- R8: Exponent field 255 with a nonzero fraction, of either sign, gives `out_int` = 0 with `out_nan` high and both `out_sat` and `out_inf` low.
- R9: `out_nan` is never high together with `out_sat` or `out_inf`, and `out_inf` is never high without `out_sat`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input word is present this cycle; acts as the clock enable of the output register |
| in_word | input | 32 | Single-precision floating-point operand |
| out_valid | output | 1 | Result registered from a word taken on the previous edge |
| out_int | output | 16 | Converted two's complement integer |
| out_sat | output | 1 | Result was clamped to a limit |
| out_inf | output | 1 | Input was an infinity |
| out_nan | output | 1 | Input was a NaN |

## Verification
Two functions meet in the same cycle at the negative end of the range. Negation of the aligned magnitude and the clamp decision both act on a magnitude of exactly 32768. The bench presents −32768.0, −32768.5 and −32769.0 in turn. It requires 0x8000 for all three, with `out_sat` low for the first two and high for the third.

Infinity detection and clamping also coincide. Both infinities are applied, and the bench expects the limit value with both `out_inf` and `out_sat` high. Back-to-back words of different classes confirm that no flag carries over from one cycle into the next.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  localparam int unsigned FP_EXP_W  = 8;
  localparam int unsigned FP_FRAC_W = 23;
  localparam int unsigned INT_W     = 16;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_class_e;

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
  import f2i_pkg::*;
#(
  parameter int unsigned EXP_W  = FP_EXP_W,
  parameter int unsigned FRAC_W = FP_FRAC_W,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIG_W  = FRAC_W + 1
) (
  input  logic [WORD_W-1:0] word_i,
  output logic              sign_o,
  output fp_class_e         cls_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [SIG_W-1:0]  sig_o
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_all0;
  logic              exp_all1;
  logic              frac_nz;

  always_comb begin
    sign_o   = word_i[WORD_W-1];
    exp_f    = word_i[FRAC_W +: EXP_W];
    frac_f   = word_i[FRAC_W-1:0];
    exp_all0 = (exp_f == '0);
    exp_all1 = (exp_f == '1);
    frac_nz  = (frac_f != '0);
  end

  always_comb begin
    if (exp_all1) begin
      cls_o = frac_nz ? CLS_NAN : CLS_INF;
    end else if (exp_all0) begin
      cls_o = CLS_ZERO;
    end else begin
      cls_o = CLS_NORM;
    end
  end

  // Hidden one is set only for normal encodings.
  always_comb begin
    exp_o = exp_f;
    sig_o = {~exp_all0, frac_f};
  end

endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
#(
  parameter int unsigned EXP_W  = FP_EXP_W,
  parameter int unsigned FRAC_W = FP_FRAC_W,
  parameter int unsigned OUT_W  = INT_W,
  localparam int unsigned SIG_W  = FRAC_W + 1,
  localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1,
  localparam int unsigned SH_W   = $clog2(OUT_W),
  localparam int unsigned WIDE_W = SIG_W + OUT_W
) (
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  output logic [OUT_W-1:0] mag_o,
  output logic             below_one_o,
  output logic             too_big_o
);

  logic [EXP_W:0]    e_unb;
  logic [SH_W-1:0]   sh_amt;
  logic [WIDE_W-1:0] wide;
  logic              unused_bits;

  // Unbiased exponent; only meaningful when exp_i >= BIAS.
  always_comb begin
    e_unb       = {1'b0, exp_i} - (EXP_W+1)'(BIAS);
    below_one_o = ({1'b0, exp_i} < (EXP_W+1)'(BIAS));
    too_big_o   = !below_one_o && (e_unb >= (EXP_W+1)'(OUT_W));
    sh_amt      = e_unb[SH_W-1:0];
  end

  // Integer part = significand shifted left by e, then the fraction bits dropped.
  always_comb begin
    wide  = {{OUT_W{1'b0}}, sig_i} << sh_amt;
    mag_o = wide[FRAC_W +: OUT_W];
  end

  assign unused_bits = ^{wide[FRAC_W-1:0], wide[WIDE_W-1:FRAC_W+OUT_W], e_unb[EXP_W:SH_W]};

endmodule

// File: rtl/f2i_clamp.sv
module f2i_clamp
  import f2i_pkg::*;
#(
  parameter int unsigned OUT_W = INT_W
) (
  input  logic             sign_i,
  input  fp_class_e        cls_i,
  input  logic [OUT_W-1:0] mag_i,
  input  logic             below_one_i,
  input  logic             too_big_i,
  output logic [OUT_W-1:0] res_o,
  output logic             sat_o,
  output logic             inf_o,
  output logic             nan_o
);

  localparam logic [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};

  logic [OUT_W-1:0] limit_v;
  logic             pos_ovf;
  logic             neg_ovf;

  always_comb begin
    limit_v = sign_i ? MIN_V : MAX_V;
    pos_ovf = !sign_i && (too_big_i || mag_i[OUT_W-1]);
    // Negative side allows one more step: a magnitude equal to MIN_V still fits.
    neg_ovf = sign_i && (too_big_i || (mag_i > MIN_V));
  end

  always_comb begin
    res_o = '0;
    sat_o = 1'b0;
    inf_o = 1'b0;
    nan_o = 1'b0;
    unique case (cls_i)
      CLS_NAN: begin
        nan_o = 1'b1;
      end
      CLS_INF: begin
        res_o = limit_v;
        sat_o = 1'b1;
        inf_o = 1'b1;
      end
      CLS_NORM: begin
        if (below_one_i) begin
          res_o = '0;
        end else if (pos_ovf || neg_ovf) begin
          res_o = limit_v;
          sat_o = 1'b1;
        end else begin
          res_o = sign_i ? (~mag_i + 1'b1) : mag_i;
        end
      end
      default: begin
        res_o = '0;
      end
    endcase
  end

  always_comb begin
    a_r9_clamp_flags_excl : assert (!(nan_o && (sat_o || inf_o)));
  end

endmodule

// File: rtl/f2i_sat16.sv
module f2i_sat16
  import f2i_pkg::*;
#(
  parameter int unsigned EXP_W       = FP_EXP_W,
  parameter int unsigned FRAC_W      = FP_FRAC_W,
  parameter int unsigned OUT_W       = INT_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned SIG_W  = FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_int,
  output logic              out_sat,
  output logic              out_inf,
  output logic              out_nan
);

  localparam logic [OUT_W-1:0] MAX_V = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] MIN_V = {1'b1, {(OUT_W-1){1'b0}}};

  // ---------------------------------------------------------------- reset
  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_q_n;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_rsync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) rst_sync[g] <= 1'b0;
          else        rst_sync[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) rst_sync[g] <= 1'b0;
          else        rst_sync[g] <= rst_sync[g-1];
        end
      end
    end
  endgenerate

  assign rst_q_n = rst_sync[SYNC_STAGES-1];

  // ---------------------------------------------------------------- datapath
  logic             f_sign;
  fp_class_e        f_cls;
  logic [EXP_W-1:0] f_exp;
  logic [SIG_W-1:0] f_sig;
  logic [OUT_W-1:0] a_mag;
  logic             a_below;
  logic             a_big;
  logic [OUT_W-1:0] c_res;
  logic             c_sat;
  logic             c_inf;
  logic             c_nan;

  f2i_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
    .word_i (in_word),
    .sign_o (f_sign),
    .cls_o  (f_cls),
    .exp_o  (f_exp),
    .sig_o  (f_sig)
  );

  f2i_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_align (
    .exp_i       (f_exp),
    .sig_i       (f_sig),
    .mag_o       (a_mag),
    .below_one_o (a_below),
    .too_big_o   (a_big)
  );

  f2i_clamp #(.OUT_W(OUT_W)) u_clamp (
    .sign_i      (f_sign),
    .cls_i       (f_cls),
    .mag_i       (a_mag),
    .below_one_i (a_below),
    .too_big_i   (a_big),
    .res_o       (c_res),
    .sat_o       (c_sat),
    .inf_o       (c_inf),
    .nan_o       (c_nan)
  );

  // ---------------------------------------------------------------- output register
  logic             vld_d;
  logic [OUT_W-1:0] int_d;
  logic             sat_d;
  logic             inf_d;
  logic             nan_d;

  always_comb begin
    vld_d = in_valid;
    if (in_valid) begin
      int_d = c_res;
      sat_d = c_sat;
      inf_d = c_inf;
      nan_d = c_nan;
    end else begin
      int_d = out_int;
      sat_d = out_sat;
      inf_d = out_inf;
      nan_d = out_nan;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid <= 1'b0;
      out_int   <= '0;
      out_sat   <= 1'b0;
      out_inf   <= 1'b0;
      out_nan   <= 1'b0;
    end else begin
      out_valid <= vld_d;
      out_int   <= int_d;
      out_sat   <= sat_d;
      out_inf   <= inf_d;
      out_nan   <= nan_d;
    end
  end

  // ---------------------------------------------------------------- assertions
  a_r1_valid_follows : assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);

  a_r1_idle_low : assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid);

  a_r1_hold : assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> ($stable(out_int) && $stable(out_sat) && $stable(out_inf) && $stable(out_nan)));

  a_r4_zero_exp : assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && (in_word[FRAC_W +: EXP_W] == '0)) |=> (out_int == '0 && !out_sat));

  a_r5_sat_limit : assert property (@(posedge clk) disable iff (!rst_q_n)
    out_sat |-> (out_int == MAX_V || out_int == MIN_V));

  a_r7_inf_sat : assert property (@(posedge clk) disable iff (!rst_q_n)
    out_inf |-> out_sat);

  a_r8_nan_zero : assert property (@(posedge clk) disable iff (!rst_q_n)
    out_nan |-> (out_int == '0 && !out_sat && !out_inf));

endmodule

// File: tb/test_f2i_sat16.sv
module test_f2i_sat16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        out_valid;
  logic [15:0] out_int;
  logic        out_sat;
  logic        out_inf;
  logic        out_nan;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  f2i_sat16 i_f2i_sat16 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_int   (out_int),
    .out_sat   (out_sat),
    .out_inf   (out_inf),
    .out_nan   (out_nan)
  );

  function automatic logic [31:0] mkf(input bit s, input int e, input int f);
    return {s, e[7:0], f[22:0]};
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic chk_out(input string req, input int v, input bit s, input bit i, input bit n);
    chk(req, "out_int", int'(out_int), v & 16'hFFFF);
    chk(req, "out_sat", int'(out_sat), int'(s));
    chk(req, "out_inf", int'(out_inf), int'(i));
    chk(req, "out_nan", int'(out_nan), int'(n));
    chk(req, "out_valid", int'(out_valid), 1);
  endtask

  // One word in; the result is registered on the following edge.
  task automatic conv(input string req, input logic [31:0] w, input int v,
                      input bit s, input bit i, input bit n);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    chk_out(req, v, s, i, n);
  endtask

  task automatic t_reset;
    chk("R2", "out_valid", int'(out_valid), 0);
    chk("R2", "out_int", int'(out_int), 0);
    chk("R2", "flags", int'({out_sat, out_inf, out_nan}), 0);
  endtask

  task automatic t_in_range;
    conv("R3", mkf(0, 127, 0), 1, 0, 0, 0);                    // 1.0
    conv("R3", mkf(0, 128, 32'h200000), 2, 0, 0, 0);           // 2.5
    conv("R3", mkf(1, 129, 32'h780000), -7, 0, 0, 0);          // -7.75
    conv("R3", mkf(0, 141, 32'h7FFE00), 32767, 0, 0, 0);       // 32767.0
    conv("R3", mkf(0, 141, 32'h7FFFFF), 32767, 0, 0, 0);       // 32767.99
    conv("R3", mkf(1, 141, 32'h7FFE00), -32767, 0, 0, 0);      // -32767.0
  endtask

  task automatic t_small;
    conv("R4", mkf(0, 126, 32'h400000), 0, 0, 0, 0);          // 0.75
    conv("R4", mkf(1, 126, 32'h7FFFFF), 0, 0, 0, 0);           // -0.99
    conv("R4", mkf(0, 0, 1), 0, 0, 0, 0);                      // subnormal
    conv("R4", mkf(1, 0, 0), 0, 0, 0, 0);                      // -0
    conv("R4", mkf(0, 0, 0), 0, 0, 0, 0);                      // +0
  endtask

  task automatic t_pos_ovf;
    conv("R5", mkf(0, 142, 0), 32767, 1, 0, 0);                // 32768.0
    conv("R5", mkf(0, 160, 32'h1502F9), 32767, 1, 0, 0);       // ~1e10
    conv("R5", mkf(0, 254, 32'h7FFFFF), 32767, 1, 0, 0);       // max normal
  endtask

  task automatic t_neg_edge;
    conv("R6", mkf(1, 142, 0), -32768, 0, 0, 0);               // -32768.0
    conv("R6", mkf(1, 142, 32'h80), -32768, 0, 0, 0);          // -32768.5
    conv("R6", mkf(1, 142, 32'h100), -32768, 1, 0, 0);         // -32769.0
    conv("R6", mkf(1, 200, 0), -32768, 1, 0, 0);               // huge negative
  endtask

  task automatic t_special;
    conv("R7", mkf(0, 255, 0), 32767, 1, 1, 0);
    conv("R7", mkf(1, 255, 0), -32768, 1, 1, 0);
    conv("R8", 32'h7FC00000, 0, 0, 0, 1);
    conv("R8", 32'hFFFFFFFF, 0, 0, 0, 1);
    conv("R8", mkf(0, 255, 1), 0, 0, 0, 1);
  endtask

  task automatic t_hold;
    conv("R1", mkf(1, 129, 32'h780000), -7, 0, 0, 0);
    for (int k = 0; k < 3; k++) begin
      in_word = mkf(0, 255, 1);
      @(negedge clk);
      chk("R1", "held out_int", int'(out_int), 16'hFFF9);
      chk("R1", "held flags", int'({out_sat, out_inf, out_nan}), 0);
      chk("R1", "out_valid low", int'(out_valid), 0);
    end
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = mkf(0, 255, 0);
    @(negedge clk);
    in_word  = 32'h7FC00000;
    chk_out("R9", 32767, 1, 1, 0);
    @(negedge clk);
    in_word  = mkf(0, 130, 32'h100000);                        // 9.0
    chk_out("R9", 0, 0, 0, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk_out("R9", 9, 0, 0, 0);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_word  = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_in_range();
    t_small();
    t_pos_ovf();
    t_neg_edge();
    t_special();
    t_hold();
    t_back_to_back();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule